// File: doc/BRIEF.md
# Clause 22 Serial Management Master

This block runs register accesses to Ethernet PHYs over the two-wire management bus. A single start pulse, together with a read/write flag, a 5-bit PHY address and a 5-bit register address, launches one frame. A write frame also carries 16 bits of write data. The block drives the management clock and the data line. The data line is split into output, output-enable and input pins, so a tri-state pad or an open-drain pull-up can be built around it. At the end of every frame the block gives a one-cycle completion pulse. For reads, the 16-bit result is also presented at that point.

The management clock comes from the system clock through a divider. Each half-period of the management clock lasts `MDC_HALF` system cycles. The default of 10 gives 2.5 MHz from a 50 MHz system clock. An enable input selects, frame by frame, whether a run of logic ones precedes the frame. Some PHYs need this run to synchronise. When no PHY answers a read, the result is all ones. A write ends with two clocks during which the data line is released.

Top module: `mdio_master`

## Requirements
- R1: While a frame runs, every high and every low half-period of `mdc` lasts exactly `MDC_HALF` system clock cycles. `mdc` is low whenever the block is idle.
- R2: When `pre_en` is high at the accepted start, `PRE_LEN` bits of value 1 are driven (`mdio_oe`=1) before the frame proper begins. When `pre_en` is low, no such bits are sent.
- R3: `mdio_o` and `mdio_oe` change only on a falling transition of `mdc`. They are stable across every rising transition, and the PHY samples on that rising transition.
- R4: A read (`rd_wr`=1) drives 14 bits, MSB first: 0,1,1,0, then `phy_addr[4:0]`, then `reg_addr[4:0]`.
- R5: After the read header, `mdio_oe` is low for 19 bit periods: two turnaround bits, 16 data bits and one idle bit. `mdio_i` is sampled in the last system cycle of each low half-period.
- R6: On read completion, `rdata` shows the 16 data bits, with the first received bit as bit 15. If the second turnaround bit was sampled high, `rdata` is 16'hFFFF instead.
- R7: A write (`rd_wr`=0) drives 32 bits, MSB first: 0,1,0,1, then `phy_addr`, then `reg_addr`, then 1,0, then `wdata[15:0]`.
- R8: After a write frame, `mdio_oe` is low for two further `mdc` periods before completion.
- R9: `busy` rises on the clock edge that accepts `start` while idle. `done` is a one-cycle pulse exactly 2·`MDC_HALF`·N cycles later, with `busy` falling on the same edge. N is `PRE_LEN` (if the preamble is used) plus 33 for a read or 34 for a write.
- R10: A `start` pulse that arrives while `busy` is high has no effect on the bits sent, on `rdata`, or on the completion time. It does not start a further frame.
- R11: After synchronous reset, `mdc`=0, `mdio_oe`=0, `busy`=0, `done`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_en | input | 1 | Send the ones preamble before the frame |
| start | input | 1 | Launch a frame (ignored while busy) |
| rd_wr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read result, valid with `done` after a read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Every result has a fixed delay measured from the accepting edge E0. The k-th rising edge of `mdc` falls on E0+(2k−1)·`MDC_HALF`. The completion pulse and `rdata` fall on E0+2·`MDC_HALF`·N. The driver counts exactly that many system edges and then checks `done` and `busy` one cycle early and again on the due cycle. A monitor samples the bus at falling system-clock edges. At each rising `mdc` transition it pops the expected `{mdio_oe, mdio_o}` bit from the scoreboard queue, and it checks that each half-period lasted `MDC_HALF` cycles. The PHY model in the bench changes `mdio_i` just after a rising `mdc` edge, so the value is settled well before the master samples it at the end of the next low half.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_RX,
    ST_TAIL
  } mdio_state_t;

  localparam int FRAME_W     = 32;
  localparam int RD_HDR_BITS = 14;
  localparam int RD_RSP_BITS = 19;
  localparam int WR_END_BITS = 2;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] bits
);
  always_ff @(posedge clk) begin
    if (rst || clr) bits <= '0;
    else if (sample) bits <= {bits[W-2:0], din};
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 10,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pre_en,
  input  logic        start,
  input  logic        rd_wr,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        done,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int MAXB = (PRE_LEN > FRAME_W) ? PRE_LEN : FRAME_W;
  localparam int BCW  = $clog2(MAXB + 1);

  mdio_state_t        state;
  logic [FRAME_W-1:0] sh;
  logic [BCW-1:0]     bcnt;
  logic               is_rd;
  logic               phase;
  logic               tick;
  logic               accept;
  logic               rx_sample;
  logic [RD_RSP_BITS-1:0] cap;

  assign accept    = (state == ST_IDLE) && start;
  assign rx_sample = (state == ST_RX) && tick && !phase;

  mdio_clkdiv #(.HALF(MDC_HALF)) u_div (
    .clk (clk),
    .rst (rst),
    .run (busy),
    .tick(tick)
  );

  mdio_rx_capture #(.W(RD_RSP_BITS)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .clr   (accept),
    .sample(rx_sample),
    .din   (mdio_i),
    .bits  (cap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sh      <= '0;
      bcnt    <= '0;
      is_rd   <= 1'b0;
      phase   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          busy    <= 1'b1;
          is_rd   <= rd_wr;
          phase   <= 1'b0;
          mdc     <= 1'b0;
          mdio_oe <= 1'b1;
          sh <= rd_wr ? {2'b01, 2'b10, phy_addr, reg_addr, 18'd0}
                      : {2'b01, 2'b01, phy_addr, reg_addr, 2'b10, wdata};
          if (pre_en) begin
            state  <= ST_PRE;
            bcnt   <= BCW'(PRE_LEN);
            mdio_o <= 1'b1;
          end else begin
            state  <= ST_HDR;
            bcnt   <= rd_wr ? BCW'(RD_HDR_BITS) : BCW'(FRAME_W);
            mdio_o <= 1'b0;
          end
        end
      end else if (tick) begin
        if (!phase) begin
          phase <= 1'b1;
          mdc   <= 1'b1;
        end else begin
          phase <= 1'b0;
          mdc   <= 1'b0;
          if (bcnt == BCW'(1)) begin
            case (state)
              ST_PRE: begin
                state  <= ST_HDR;
                bcnt   <= is_rd ? BCW'(RD_HDR_BITS) : BCW'(FRAME_W);
                mdio_o <= sh[FRAME_W-1];
              end
              ST_HDR: begin
                state   <= is_rd ? ST_RX : ST_TAIL;
                bcnt    <= is_rd ? BCW'(RD_RSP_BITS) : BCW'(WR_END_BITS);
                mdio_oe <= 1'b0;
                mdio_o  <= 1'b0;
              end
              default: begin
                state <= ST_IDLE;
                busy  <= 1'b0;
                done  <= 1'b1;
                if (state == ST_RX)
                  rdata <= cap[RD_RSP_BITS-2] ? 16'hFFFF : cap[16:1];
              end
            endcase
          end else begin
            bcnt <= bcnt - 1'b1;
            if (state == ST_HDR) begin
              sh     <= sh << 1;
              mdio_o <= sh[FRAME_W-2];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int MDC_HALF = 10
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  localparam int GW = $clog2(2 * MDC_HALF + 2);
  localparam logic [GW-1:0] GMAX = GW'(2 * MDC_HALF + 1);

  logic          mq;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      mq  <= 1'b0;
      gap <= '0;
    end else begin
      mq <= mdc;
      if (mdc != mq) gap <= '0;
      else if (gap != GMAX) gap <= gap + 1'b1;
    end
  end

  a_r1_half_period: assert property (@(posedge clk) disable iff (rst)
    (mdc != mq) |-> (gap >= GW'(MDC_HALF - 1)));

  a_r11_idle_bus: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  a_r3_stable_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r9_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r8_released_at_end: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!mdio_oe));
endmodule

bind mdio_master mdio_master_chk #(.MDC_HALF(MDC_HALF)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .mdc    (mdc),
  .mdio_o (mdio_o),
  .mdio_oe(mdio_oe)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int H   = 10;
  localparam int PRE = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_en = 1'b0;
  logic        start = 1'b0;
  logic        rd_wr = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        done, busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  always #10 clk = ~clk;

  mdio_master #(.MDC_HALF(H), .PRE_LEN(PRE)) i_mdio_master (
    .clk(clk), .rst(rst), .pre_en(pre_en), .start(start), .rd_wr(rd_wr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata),
    .done(done), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    logic  oe;
    logic  v;
    string req;
  } bit_t;

  typedef struct {
    logic        rd;
    logic [15:0] data;
  } res_t;

  bit_t bq[$];
  res_t rq[$];

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  int          rises = 0;
  int          rx_base = 1 << 30;
  logic [18:0] resp = '1;

  assign mdio_i = (rises >= rx_base && rises < rx_base + 19)
                  ? resp[18 - (rises - rx_base)] : 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: bus bits, half periods, results
  logic pm = 1'b0, pb = 1'b0;
  int   hc = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy && !pb) hc = 0;
      else hc++;
      if (mdc !== pm) begin
        check("R1 half period", hc, H);
        hc = 0;
        if (mdc === 1'b1) begin
          rises++;
          if (bq.size() == 0) check("R3 unexpected mdc rise", 1, 0);
          else begin
            bit_t e;
            e = bq.pop_front();
            check({e.req, " oe"}, {31'd0, mdio_oe}, {31'd0, e.oe});
            if (e.oe) check({e.req, " data"}, {31'd0, mdio_o}, {31'd0, e.v});
          end
        end
      end
      if (done === 1'b1) begin
        if (rq.size() == 0) check("R10 unexpected done", 1, 0);
        else begin
          res_t r;
          r = rq.pop_front();
          if (r.rd) check("R6 rdata", {16'd0, rdata}, {16'd0, r.data});
        end
      end
    end
    pm = mdc;
    pb = busy;
  end

  task automatic push(input logic oe, input logic v, input string req);
    bit_t b;
    b.oe = oe; b.v = v; b.req = req;
    bq.push_back(b);
  endtask

  task automatic txn(input bit rd, input bit pre, input logic [4:0] pa,
                     input logic [4:0] ra, input logic [15:0] wd,
                     input logic [18:0] rsp, input bit inj);
    logic [31:0] fr;
    int n;
    int hdr;
    res_t r;
    if (pre) for (int i = 0; i < PRE; i++) push(1, 1, "R2 preamble");
    if (rd) begin
      fr = {2'b01, 2'b10, pa, ra, 18'd0};
      for (int i = 31; i > 17; i--) push(1, fr[i], "R4 read header");
      for (int i = 0; i < 19; i++) push(0, 0, "R5 read release");
    end else begin
      fr = {2'b01, 2'b01, pa, ra, 2'b10, wd};
      for (int i = 31; i >= 0; i--) push(1, fr[i], "R7 write frame");
      for (int i = 0; i < 2; i++) push(0, 0, "R8 write idle");
    end
    r.rd = rd;
    r.data = rsp[17] ? 16'hFFFF : rsp[16:1];
    rq.push_back(r);
    hdr = (pre ? PRE : 0) + 14;
    n = (pre ? PRE : 0) + (rd ? 33 : 34);
    resp = rsp;
    rx_base = rd ? rises + hdr : (1 << 30);
    @(negedge clk);
    pre_en = pre; rd_wr = rd; phy_addr = pa; reg_addr = ra; wdata = wd;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    pre_en = 1'b0;
    check("R9 busy after accept", {31'd0, busy}, 1);
    for (int c = 1; c < 2 * H * n; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (inj && c == 200) begin
        start = 1'b1; rd_wr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd; pre_en = 1'b1;
      end else start = 1'b0;
    end
    start = 1'b0;
    check("R9 done early", {31'd0, done}, 0);
    @(posedge clk);
    @(negedge clk);
    check("R9 done due", {31'd0, done}, 1);
    check("R9 busy cleared", {31'd0, busy}, 0);
    @(posedge clk);
    @(negedge clk);
    check("R9 done single pulse", {31'd0, done}, 0);
    repeat (3 * H) @(negedge clk);
    check("R10 no extra frame", {31'd0, busy}, 0);
    check("R1 mdc idle low", {31'd0, mdc}, 0);
    check("R11 released when idle", {31'd0, mdio_oe}, 0);
    check("R2 all bits sent", bq.size(), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R11 reset mdc", {31'd0, mdc}, 0);
    check("R11 reset oe", {31'd0, mdio_oe}, 0);
    check("R11 reset busy", {31'd0, busy}, 0);
    check("R11 reset done", {31'd0, done}, 0);
    check("R11 reset rdata", {16'd0, rdata}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    txn(0, 0, 5'h03, 5'h11, 16'hBEEF, '1, 0);
    txn(1, 1, 5'h01, 5'h02, 16'h0000, {2'b10, 16'hA5C3, 1'b1}, 0);
    txn(1, 0, 5'h1F, 5'h00, 16'h0000, '1, 0);
    txn(0, 1, 5'h15, 5'h0A, 16'h1234, '1, 1);
    txn(1, 0, 5'h1F, 5'h1F, 16'h0000, {2'b10, 16'h0001, 1'b1}, 1);
    txn(1, 0, 5'h00, 5'h07, 16'h0000, {2'b10, 16'hFFFE, 1'b0}, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule